// File: doc/BRIEF.md
# Serially Loaded Pulse-Density DAC Core

This block is a one-bit digital-to-analog converter core. A host loads an 8-bit unsigned level over three slow wires: a serial clock, a data line and a latch strobe. The block shifts one data bit in on each rising edge of the serial clock, with the most significant bit first. When the latch strobe is asserted, it copies the shift register into the level register. It then drives a single output whose density of ones equals the level divided by 256. An external RC low-pass filter turns that output into an analog voltage.

The three serial wires are asynchronous to the system clock. Each one passes through a synchronizer. A free-running frame counter then polls the wires once every 26 system clocks, and the poll uses edge detection. A first-order delta-sigma modulator, built as an 8-bit accumulator, advances twice per frame, once every 13 clocks. Because the wires are polled slowly, the host must hold every change on them for at least one full frame.

Top module: `pdm_serial_dac`

## Requirements
- R1: After reset the output is low. The shift register, the level register and the accumulator are all zero, so the output stays low until a non-zero level is latched.
- R2: For a latched level n, any window of 256 consecutive modulator ticks holds exactly n ones on the output.
- R3: A data bit is taken on each rising edge of the serial clock, and the first bit sent ends up as bit 7 of the level.
- R4: Bits shifted in without a latch strobe do not change the output density. An active latch strobe, detected on its rising edge, applies the shifted value.
- R5: A second latch strobe with no new bits shifted in leaves the level unchanged.
- R6: The output changes only on a modulator tick, and ticks are exactly 13 system clocks apart.
- R7: Level 0 gives a constant low output, and level 255 gives exactly one low tick in every 256.
- R8: The serial wires are polled once per 26-clock frame. Each serial clock phase held for at least one frame plus the synchronizer delay shifts in exactly one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock from the host, asynchronous |
| serData | input | 1 | Serial data, MSB first, asynchronous |
| serLatch | input | 1 | Latch strobe; polarity set by parameter |
| pdmOut | output | 1 | Pulse-density modulated output |

## Verification
The bench sweeps a set of levels: 0, 1, 2, 127, 128, 129, 170, 85, 254 and 255. For each one it counts high cycles over exactly 256 ticks. Single-bit levels at opposite ends (1 and 128) separate MSB-first from LSB-first shifting, and the extremes expose an overflowing or truncated accumulator. Loading new bits without a latch, then latching again with no bits, shows whether the level register is held or overwritten. With level 128 the output alternates, so its run lengths measure the tick spacing directly.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;
  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic pollPins;  // once per frame: sample the serial wires
    logic modTick;   // twice per frame: advance the modulator
  } dacStrobes_t;
endpackage

// File: rtl/pdm_dac_ctrl.sv
module pdm_dac_ctrl
  import pdm_dac_pkg::*;
#(
  parameter int TICK_DIV = 13
) (
  input  logic        clk,
  input  logic        rstN,
  output dacStrobes_t strobes
);
  localparam int FRAME_LEN = 2 * TICK_DIV;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  logic [CNT_W-1:0] frameCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   frameCnt <= '0;
    else if (frameCnt == CNT_W'(FRAME_LEN - 1))  frameCnt <= '0;
    else                                         frameCnt <= frameCnt + 1'b1;
  end

  always_comb begin
    strobes.pollPins = (frameCnt == '0);
    strobes.modTick  = (frameCnt == '0) || (frameCnt == CNT_W'(TICK_DIV));
  end

  // R6
  frame_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt < CNT_W'(FRAME_LEN));

  // R8
  poll_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pollPins |=> !strobes.pollPins);
endmodule

// File: rtl/pdm_dac_datapath.sv
module pdm_dac_datapath
  import pdm_dac_pkg::*;
#(
  parameter int LEVEL_W           = 8,
  parameter int SYNC_STAGES       = 2,
  parameter bit LATCH_ACTIVE_HIGH = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  dacStrobes_t strobes,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLatch,
  output logic        pdmOut
);
  localparam int PIN_N   = 3;
  localparam int PIN_CLK = 0;
  localparam int PIN_DAT = 1;
  localparam int PIN_LAT = 2;

  logic [PIN_N-1:0] pinRaw;
  logic [PIN_N-1:0] syncChain [SYNC_STAGES];
  logic [PIN_N-1:0] pinSync;
  logic [PIN_N-1:0] polled;
  logic [PIN_N-1:0] pinRise;

  logic [LEVEL_W-1:0] shiftReg;
  logic [LEVEL_W-1:0] levelReg;
  logic [LEVEL_W-1:0] accum;
  logic [LEVEL_W:0]   accSum;

  // Normalise the latch polarity so that 1 always means "latch"
  assign pinRaw[PIN_CLK] = serClk;
  assign pinRaw[PIN_DAT] = serData;
  assign pinRaw[PIN_LAT] = LATCH_ACTIVE_HIGH ? serLatch : ~serLatch;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= pinRaw;
        else             syncChain[s] <= syncChain[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign pinSync = syncChain[SYNC_STAGES-1];
  assign pinRise = strobes.pollPins ? (pinSync & ~polled) : '0;

  // Poll the wires once per frame; edges are relative to the last poll
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 polled <= '0;
    else if (strobes.pollPins) polled <= pinSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftReg <= '0;
    else if (pinRise[PIN_CLK]) shiftReg <= {shiftReg[LEVEL_W-2:0], pinSync[PIN_DAT]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 levelReg <= '0;
    else if (pinRise[PIN_LAT]) levelReg <= shiftReg;
  end

  // First-order modulator: the carry out of the accumulator is the output bit
  assign accSum = {1'b0, accum} + {1'b0, levelReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accum  <= '0;
      pdmOut <= 1'b0;
    end else if (strobes.modTick) begin
      accum  <= accSum[LEVEL_W-1:0];
      pdmOut <= accSum[LEVEL_W];
    end
  end

  // R6
  out_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pdmOut) |-> $past(strobes.modTick));

  // R7
  zero_level_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.modTick && levelReg == '0) |=> !pdmOut);

  // R4
  level_on_poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(levelReg) |-> $past(strobes.pollPins));

  // R8
  shift_on_poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shiftReg) |-> $past(strobes.pollPins));
endmodule

// File: rtl/pdm_serial_dac.sv
module pdm_serial_dac
  import pdm_dac_pkg::*;
#(
  parameter int LEVEL_W           = 8,
  parameter int TICK_DIV          = 13,
  parameter int SYNC_STAGES       = 2,
  parameter bit LATCH_ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic serData,
  input  logic serLatch,
  output logic pdmOut
);
  dacStrobes_t strobes;

  pdm_dac_ctrl #(.TICK_DIV(TICK_DIV)) i_ctrl (
    .clk(clk), .rstN(rstN), .strobes(strobes)
  );

  pdm_dac_datapath #(
    .LEVEL_W(LEVEL_W), .SYNC_STAGES(SYNC_STAGES),
    .LATCH_ACTIVE_HIGH(LATCH_ACTIVE_HIGH)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .serClk(serClk), .serData(serData), .serLatch(serLatch),
    .pdmOut(pdmOut)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) $rose(rstN) |-> !pdmOut);
endmodule

// File: tb/test_pdm_serial_dac.sv
module test_pdm_serial_dac;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 13;
  localparam int HOLD       = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLatch = 1'b0;
  logic pdmOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  pdm_serial_dac i_pdm_serial_dac (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .pdmOut(pdmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic shiftByte(input logic [7:0] v);
    for (int b = 7; b >= 0; b--) begin
      serData = v[b];
      serClk = 1'b0; waitCyc(HOLD);
      serClk = 1'b1; waitCyc(HOLD);
    end
    serClk = 1'b0; waitCyc(HOLD);
  endtask

  task automatic pulseLatch;
    serLatch = 1'b1; waitCyc(HOLD);
    serLatch = 1'b0; waitCyc(HOLD);
  endtask

  // High cycles over 256 ticks; each tick value lasts TICK cycles
  task automatic countOnes(output int ones);
    int hi = 0;
    for (int c = 0; c < 256 * TICK; c++) begin
      @(negedge clk);
      if (pdmOut) hi++;
    end
    ones = hi / TICK;
  endtask

  task automatic loadAndMeasure(input logic [7:0] v, input string req);
    int ones;
    shiftByte(v);
    pulseLatch();
    waitCyc(100);
    countOnes(ones);
    check(req, ones, v);
  endtask

  initial begin
    int ones;
    int lastChange;
    logic prev;
    waitCyc(5);
    // R1: reset state
    check("R1 reset output", pdmOut, 0);
    rstN = 1'b1;
    waitCyc(10);
    countOnes(ones);
    check("R1 level zero after reset", ones, 0);

    // R2 / R3 / R7: sweep of levels
    loadAndMeasure(8'd0,   "R7 level 0");
    loadAndMeasure(8'd1,   "R3 level 1 (LSB)");
    loadAndMeasure(8'd128, "R3 level 128 (MSB first)");
    loadAndMeasure(8'd2,   "R2 level 2");
    loadAndMeasure(8'd127, "R2 level 127");
    loadAndMeasure(8'd129, "R2 level 129");
    loadAndMeasure(8'd170, "R8 level 170 alternating bits");
    loadAndMeasure(8'd85,  "R8 level 85 alternating bits");
    loadAndMeasure(8'd254, "R2 level 254");
    loadAndMeasure(8'd255, "R7 level 255");

    // R4: shift without latch keeps level 255
    shiftByte(8'd3);
    waitCyc(100);
    countOnes(ones);
    check("R4 shift without latch", ones, 255);
    // R4: latch applies the pending value
    pulseLatch();
    waitCyc(100);
    countOnes(ones);
    check("R4 latch applies shifted value", ones, 3);
    // R5: latch again with no new bits
    pulseLatch();
    waitCyc(100);
    countOnes(ones);
    check("R5 relatch no new bits", ones, 3);

    // R6: level 128 toggles every tick; run lengths equal TICK
    loadAndMeasure(8'd128, "R6 setup level 128");
    prev = pdmOut;
    lastChange = -1;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (pdmOut != prev) begin
        if (lastChange >= 0) check("R6 tick spacing", c - lastChange, TICK);
        lastChange = c;
        prev = pdmOut;
      end
    end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 200000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule